// File: doc/BRIEF.md
# Shift-Register Return-Address Stack

This block holds return addresses for a small processor core in a fixed set of sixteen 16-bit entries with no stack pointer. Every push moves the whole array down one place and every pop moves it up one place, so the current top is always in position 0. The only other access is a direct overwrite of the top entry. There are no full or empty flags. A push onto a full stack silently drops the oldest address. A pop always refills the bottom with all-ones, so a drained stack returns 0xFFFF.

The caller drives one 16-bit operand and three request strobes. The block presents the top entry continuously. For each pop it gives the popped word with a one-cycle valid strobe. The whole array is also brought out flat, so a checker can compare the full state.

Top module: `rstk_top`

## Requirements
- R1: On a clock edge with `rst_n` low, all sixteen entries become 0xFFFF and `pop_valid_o` becomes 0.
- R2: A push without pop writes `data_i` into position 0, and each entry i (0 to 14) moves to position i+1 at the next edge.
- R3: When a push happens while position 15 holds data, the old position-15 value is lost and no flag or error is raised.
- R4: A pop makes `pop_valid_o` high for the following cycle, with `pop_data_o` equal to the top entry from before that edge.
- R5: A pop without push moves each entry i (1 to 15) to position i-1 and loads 0xFFFF into position 15.
- R6: Popping a stack that holds only fill values returns 0xFFFF, with no error indication.
- R7: A top write without push or pop replaces position 0 with `data_i` and leaves positions 1 to 15 unchanged.
- R8: A push and a pop in the same cycle replace position 0 with `data_i` and leave positions 1 to 15 unchanged. `pop_data_o` shows the old top with `pop_valid_o` high.
- R9: A top write asserted together with push or pop is ignored, and the push or pop behaves exactly as it would alone.
- R10: With no request asserted, the array stays unchanged and `pop_valid_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push `data_i` onto the stack |
| pop_i | input | 1 | Pop the top entry |
| wr_top_i | input | 1 | Overwrite the top entry with `data_i` |
| data_i | input | 16 | Operand for push or top write |
| top_o | output | 16 | Current top entry (position 0) |
| pop_data_o | output | 16 | Word removed by the last pop |
| pop_valid_o | output | 1 | High for one cycle after each pop |
| entries_o | output | 256 | All entries; position i is at bits [16*i+15 : 16*i] |

## Verification
The assertions check four things on every cycle: the top after a push, the fill of the bottom after a pop, the pop data and strobe, and that the lower entries stay put under a top write or when no request is given. Only the bench scenarios can show the behaviour that depends on history: the dropped oldest entry after more than sixteen pushes, the 0xFFFF returns from a drained stack, the combined push-and-pop case, and the priority over a top write. The bench checks these against a model of the full array.

// File: rtl/rstk_pkg.sv
// Shared definitions for the return-address stack.
// Assumes a single operation per cycle as decoded by rstk_opdec.
package rstk_pkg;

    // Operation applied to every entry in one cycle
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,  // keep contents
        OP_SHDN = 2'd1,  // push: move down, new value on top
        OP_SHUP = 2'd2,  // pop: move up, fill at bottom
        OP_REPL = 2'd3   // replace top only
    } rstk_op_e;

endpackage

// File: rtl/rstk_opdec.sv
// Request decoder: turns the push / pop / top-write strobes into one array
// operation. Push together with pop gives a top replace. Push or pop wins
// over a top write. Purely combinational.
module rstk_opdec
    import rstk_pkg::*;
(
    input  logic     push,
    input  logic     pop,
    input  logic     wr_top,
    output rstk_op_e op
);

    // Pick the operation by priority
    always_comb begin
        if (push && pop)  op = OP_REPL;
        else if (push)    op = OP_SHDN;
        else if (pop)     op = OP_SHUP;
        else if (wr_top)  op = OP_REPL;
        else              op = OP_HOLD;
    end

endmodule

// File: rtl/rstk_cell.sv
// One stack entry. It loads its upper neighbour on a push and its lower
// neighbour on a pop. The top cell takes `above` (the operand) on a
// replace. Assumes the parent wires the operand to `above` of cell 0 and
// the fill value to `below` of the last cell.
module rstk_cell
    import rstk_pkg::*;
#(
    parameter int          W      = 16,
    parameter logic [W-1:0] FILL  = '1,
    parameter bit          IS_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  rstk_op_e     op,
    input  logic [W-1:0] above,
    input  logic [W-1:0] below,
    output logic [W-1:0] q
);

    // Entry register with fill on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= FILL;
        end else begin
            case (op)
                OP_SHDN: q <= above;
                OP_SHUP: q <= below;
                OP_REPL: if (IS_TOP) q <= above;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/rstk_popreg.sv
// Pop capture: registers the top entry and a one-cycle valid strobe on
// each pop. Assumes `top` is the pre-edge top entry.
module rstk_popreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pop_req,
    input  logic [W-1:0] top,
    output logic [W-1:0] pop_data,
    output logic         pop_valid
);

    // Capture the popped word and raise the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= pop_req;
            if (pop_req) pop_data <= top;
        end
    end

    // R10
    no_pop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> !pop_valid);

endmodule

// File: rtl/rstk_top.sv
// Return-address stack built from shifting entries, with no pointer.
// Position 0 is the top. A pop fills the bottom with FILL, and a push past
// the depth drops the oldest entry. Reset is synchronous and active low.
module rstk_top
    import rstk_pkg::*;
#(
    parameter int           W     = 16,
    parameter int           DEPTH = 16,
    parameter logic [W-1:0] FILL  = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic               wr_top_i,
    input  logic [W-1:0]       data_i,
    output logic [W-1:0]       top_o,
    output logic [W-1:0]       pop_data_o,
    output logic               pop_valid_o,
    output logic [DEPTH*W-1:0] entries_o
);

    localparam int LAST = DEPTH - 1;

    rstk_op_e     op;
    logic [W-1:0] ent [DEPTH];

    rstk_opdec u_dec (
        .push   (push_i),
        .pop    (pop_i),
        .wr_top (wr_top_i),
        .op     (op)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;

        if (i == 0) begin : g_first
            assign from_above = data_i;
        end else begin : g_mid_a
            assign from_above = ent[i-1];
        end

        if (i == LAST) begin : g_last
            assign from_below = FILL;
        end else begin : g_mid_b
            assign from_below = ent[i+1];
        end

        rstk_cell #(
            .W      (W),
            .FILL   (FILL),
            .IS_TOP (i == 0)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op),
            .above (from_above),
            .below (from_below),
            .q     (ent[i])
        );

        assign entries_o[i*W +: W] = ent[i];
    end

    assign top_o = ent[0];

    rstk_popreg #(.W(W)) u_pop (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (pop_i),
        .top       (ent[0]),
        .pop_data  (pop_data_o),
        .pop_valid (pop_valid_o)
    );

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (top_o == $past(data_i)));

    // R5
    pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (entries_o[LAST*W +: W] == FILL));

    // R4
    pop_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> (pop_valid_o && pop_data_o == $past(top_o)));

    // R7
    wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_top_i && !push_i && !pop_i) |=>
            (entries_o[DEPTH*W-1:W] == $past(entries_o[DEPTH*W-1:W])
             && top_o == $past(data_i)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !wr_top_i) |=> $stable(entries_o));

endmodule

// File: tb/tb_rstk_top.sv
module tb_rstk_top;

    localparam int W = 16;
    localparam int D = 16;
    localparam logic [W-1:0] FILLV = 16'hFFFF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           push_i = 1'b0, pop_i = 1'b0, wr_top_i = 1'b0;
    logic [W-1:0]   data_i = '0;
    logic [W-1:0]   top_o, pop_data_o;
    logic           pop_valid_o;
    logic [D*W-1:0] entries_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] model [D];
    logic         exp_pv = 1'b0;
    logic [W-1:0] exp_pd = '0;

    rstk_top dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .wr_top_i(wr_top_i), .data_i(data_i), .top_o(top_o),
        .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
        .entries_o(entries_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare the full array, top and pop outputs with the model
    task automatic check_state(input string tag);
        for (int i = 0; i < D; i++)
            chk(entries_o[i*W +: W] === model[i], tag, entries_o[i*W +: W], model[i]);
        chk(top_o === model[0], tag, top_o, model[0]);
        chk(pop_valid_o === exp_pv, tag, {15'd0, pop_valid_o}, {15'd0, exp_pv});
        if (exp_pv) chk(pop_data_o === exp_pd, tag, pop_data_o, exp_pd);
    endtask

    // One cycle of stimulus, called just after a falling edge
    task automatic step(input bit pu, input bit po, input bit wr, input logic [W-1:0] d);
        push_i = pu; pop_i = po; wr_top_i = wr; data_i = d;
        @(posedge clk);
        exp_pv = po;
        if (po) exp_pd = model[0];
        if (pu && po) model[0] = d;
        else if (pu) begin
            for (int i = D-1; i > 0; i--) model[i] = model[i-1];
            model[0] = d;
        end else if (po) begin
            for (int i = 0; i < D-1; i++) model[i] = model[i+1];
            model[D-1] = FILLV;
        end else if (wr) model[0] = d;
        @(negedge clk);
        push_i = 0; pop_i = 0; wr_top_i = 0;
    endtask

    task automatic t_reset();  // R1
        step(1, 0, 0, 16'h1234);
        rst_n = 0;
        @(posedge clk);
        for (int i = 0; i < D; i++) model[i] = FILLV;
        exp_pv = 0;
        @(negedge clk);
        rst_n = 1;
        check_state("R1 reset");
    endtask

    task automatic t_push();  // R2
        for (int k = 0; k < 5; k++) step(1, 0, 0, 16'h0100 + 16'(k));
        check_state("R2 push");
    endtask

    task automatic t_pop();  // R4 R5
        step(0, 1, 0, 16'h0);
        check_state("R4 pop word");
        step(0, 1, 0, 16'h0);
        check_state("R5 pop shift fill");
    endtask

    task automatic t_overflow();  // R3
        for (int k = 0; k < D + 3; k++) step(1, 0, 0, 16'hA000 + 16'(k));
        check_state("R3 overflow drop");
    endtask

    task automatic t_drain();  // R6
        for (int k = 0; k < D + 2; k++) begin
            step(0, 1, 0, 16'h0);
            check_state("R6 drain");
        end
        chk(pop_data_o === FILLV, "R6 empty pop", pop_data_o, FILLV);
    endtask

    task automatic t_wr();  // R7
        step(1, 0, 0, 16'h1111);
        step(1, 0, 0, 16'h2222);
        step(0, 0, 1, 16'h5A5A);
        check_state("R7 top write");
    endtask

    task automatic t_both();  // R8
        step(1, 1, 0, 16'hBEEF);
        check_state("R8 push and pop");
        chk(pop_data_o === 16'h5A5A, "R8 old top", pop_data_o, 16'h5A5A);
    endtask

    task automatic t_prio();  // R9
        step(1, 0, 1, 16'h3333);
        check_state("R9 write with push");
        step(0, 1, 1, 16'h4444);
        check_state("R9 write with pop");
    endtask

    task automatic t_idle();  // R10
        step(0, 0, 0, 16'h7777);
        step(0, 0, 0, 16'h8888);
        check_state("R10 idle");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) model[i] = FILLV;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_state("R1 after reset");
        t_push();
        t_pop();
        t_overflow();
        t_drain();
        t_wr();
        t_both();
        t_prio();
        t_idle();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule